// File: doc/BRIEF.md
# Sixteen-Pin GPIO Controller with Masked Output Writes and a Shared Interrupt

This block drives and senses sixteen general-purpose pins from a memory-mapped register bus. Software sets the drive direction of each pin. It updates output latches with a single 32-bit store: the upper half of the word is a per-bit write mask for the lower half, so one bit can be flipped without a read-modify-write sequence. The synchronized level of every pin can be read back.

The upper eight pins feed one level-sensitive interrupt request. Each of those pins is ANDed with its own enable bit, and the eight products are ORed together. This suits active-high sources. A small enable register holds a clock-enable bit and a soft-reset bit. The controller does nothing useful until software has turned its clock on and released the soft reset. A write of 3 followed by a write of 1 brings it up. A write of 2 puts it back into reset with its clock stopped.

Top module: `mwgpio`

## Requirements
- R1: The direction register is at offset 0x00. Bit n at 1 makes pin n an output (`pin_oe[n]` high) and bit n at 0 makes it an input. Bits 15:0 read back, and bits 31:16 read as zero.
- R2: The output register is at offset 0x08. On a write, bit n of the data is loaded into the latch of pin n only where bit n+16 is 1. The latch appears on `pin_out` and reads back in bits 15:0, with bits 31:16 reading as zero.
- R3: On an output-register write, every latch whose mask bit (n+16) is 0 keeps its previous value. A write with an all-zero mask changes nothing.
- R4: The pin-state register is at offset 0x0C and is read-only. It returns the `pin_in` levels through a two-stage synchronizer, so a change becomes visible after the second rising clock edge. Writes to it have no effect.
- R5: The interrupt-enable register is at offset 0x10. Its bits 7:0 enable pins 8..15, and bits 31:8 read as zero. `irq_shared` is high exactly when some enabled pin among 8..15 has a synchronized level of 1. Pins 0..7 never raise it.
- R6: The block-enable register is at offset 0x14. Bit 0 is the clock enable and bit 1 is the soft reset. Writes to any other register take effect only while the clock enable is 1 and the soft reset is 0.
- R7: While the clock enable is 0, the pin-state register holds its last value and `irq_shared` is low.
- R8: While the soft-reset bit is 1, the direction, output, interrupt-enable and pin-state registers are cleared to 0. The sequence "write 3, then write 1" leaves the block running with all of these registers at 0.
- R9: Reads from unmapped offsets, and any read with `bus_sel` low, return 0. Writes to unmapped offsets have no effect.
- R10: After the hardware reset, every register reads 0, and `pin_oe`, `pin_out` and `irq_shared` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| pin_in | input | 16 | Pin levels from the pads |
| pin_out | output | 16 | Output latch values |
| pin_oe | output | 16 | Per-pin output enable |
| irq_shared | output | 1 | Shared level interrupt from pins 8..15 |

## Verification
The assertions check on every cycle that:
- a masked output write leaves the unmasked latches untouched;
- the soft reset empties the direction, output and enable registers one cycle later;
- writes are dropped while the clock is off;
- pin sampling holds still while the clock is off;
- the shared interrupt is only ever raised with an enable bit set and a high upper pin behind it.

The bench scenarios cover the behaviours that depend on sequences of accesses:
- the exact two-edge latency of the synchronizer;
- that the lower pins are ignored by the interrupt;
- the 3-then-1 bring-up and the 2 shutdown;
- the values that unmapped offsets and deselected reads return.

// File: rtl/mwgpio_pkg.sv
package mwgpio_pkg;

  localparam int OFF_DIR = 'h00;
  localparam int OFF_OUT = 'h08;
  localparam int OFF_PIN = 'h0C;
  localparam int OFF_IEN = 'h10;
  localparam int OFF_BEN = 'h14;

  localparam int BEN_CLKEN_BIT = 0;
  localparam int BEN_SRST_BIT  = 1;

  typedef enum logic [2:0] {
    SEL_DIR,
    SEL_OUT,
    SEL_PIN,
    SEL_IEN,
    SEL_BEN,
    SEL_NONE
  } reg_sel_e;

endpackage

// File: rtl/mwgpio_sync.sv
module mwgpio_sync #(
  parameter int NPINS  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             srst,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] state
);

  logic [NPINS-1:0] stg_q [STAGES];
  logic [NPINS-1:0] stg_d [STAGES];
  logic             stg_ce;

  assign stg_ce = clk_en | srst;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_comb stg_d[s] = srst ? '0 : pin_in;
      end else begin : g_next
        always_comb stg_d[s] = srst ? '0 : stg_q[s-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      stg_q[s] <= '0;
        else if (stg_ce) stg_q[s] <= stg_d[s];
      end
    end
  endgenerate

  assign state = stg_q[STAGES-1];

  AST_STATE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en && !srst) |=> $stable(state)); // R7

endmodule

// File: rtl/mwgpio_irq.sv
module mwgpio_irq #(
  parameter int NPINS   = 16,
  parameter int NSHARED = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clk_en,
  input  logic [NPINS-1:0]   state,
  input  logic [NSHARED-1:0] ien,
  output logic               irq_o
);

  localparam int SH_LO = NPINS - NSHARED;

  logic [NSHARED-1:0] gated;

  generate
    for (genvar k = 0; k < NSHARED; k++) begin : g_gate
      assign gated[k] = state[SH_LO+k] & ien[k];
    end
  endgenerate

  assign irq_o = clk_en & (|gated);

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|ien)); // R5
  AST_IRQ_NEEDS_HIGH_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|state[NPINS-1:SH_LO])); // R5

endmodule

// File: rtl/mwgpio_regs.sv
module mwgpio_regs
  import mwgpio_pkg::*;
#(
  parameter int NPINS   = 16,
  parameter int NSHARED = 8,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [2*NPINS-1:0] bus_wdata,
  output logic [2*NPINS-1:0] bus_rdata,
  input  logic [NPINS-1:0]   pin_state,
  output logic [NPINS-1:0]   dir_q,
  output logic [NPINS-1:0]   out_q,
  output logic [NSHARED-1:0] ien_q,
  output logic               clken_q,
  output logic               srst_q
);

  localparam int DW = 2 * NPINS;

  reg_sel_e           sel;
  logic               wr_en;
  logic               wr_live;
  logic [NPINS-1:0]   wmask;
  logic [NPINS-1:0]   wval;
  logic [NPINS-1:0]   dir_d;
  logic [NPINS-1:0]   out_d;
  logic [NSHARED-1:0] ien_d;
  logic               clken_d;
  logic               srst_d;
  logic               cfg_ce;
  logic               ben_ce;

  always_comb begin
    if      (bus_addr == ADDR_W'(OFF_DIR)) sel = SEL_DIR;
    else if (bus_addr == ADDR_W'(OFF_OUT)) sel = SEL_OUT;
    else if (bus_addr == ADDR_W'(OFF_PIN)) sel = SEL_PIN;
    else if (bus_addr == ADDR_W'(OFF_IEN)) sel = SEL_IEN;
    else if (bus_addr == ADDR_W'(OFF_BEN)) sel = SEL_BEN;
    else                                   sel = SEL_NONE;
  end

  assign wr_en   = bus_sel & bus_wr;
  assign wr_live = wr_en & clken_q & ~srst_q;
  assign wmask   = bus_wdata[DW-1:NPINS];
  assign wval    = bus_wdata[NPINS-1:0];

  always_comb begin
    dir_d = dir_q;
    out_d = out_q;
    ien_d = ien_q;
    if (srst_q) begin
      dir_d = '0;
      out_d = '0;
      ien_d = '0;
    end else if (wr_live) begin
      case (sel)
        SEL_DIR: dir_d = wval;
        SEL_OUT: out_d = (out_q & ~wmask) | (wval & wmask);
        SEL_IEN: ien_d = bus_wdata[NSHARED-1:0];
        default: ;
      endcase
    end
  end

  assign cfg_ce = srst_q | wr_live;

  always_comb begin
    clken_d = bus_wdata[BEN_CLKEN_BIT];
    srst_d  = bus_wdata[BEN_SRST_BIT];
  end

  assign ben_ce = wr_en & (sel == SEL_BEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
      ien_q <= '0;
    end else if (cfg_ce) begin
      dir_q <= dir_d;
      out_q <= out_d;
      ien_q <= ien_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clken_q <= 1'b0;
      srst_q  <= 1'b0;
    end else if (ben_ce) begin
      clken_q <= clken_d;
      srst_q  <= srst_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      case (sel)
        SEL_DIR: bus_rdata = {{(DW-NPINS){1'b0}}, dir_q};
        SEL_OUT: bus_rdata = {{(DW-NPINS){1'b0}}, out_q};
        SEL_PIN: bus_rdata = {{(DW-NPINS){1'b0}}, pin_state};
        SEL_IEN: bus_rdata = {{(DW-NSHARED){1'b0}}, ien_q};
        SEL_BEN: begin
          bus_rdata[BEN_CLKEN_BIT] = clken_q;
          bus_rdata[BEN_SRST_BIT]  = srst_q;
        end
        default: bus_rdata = '0;
      endcase
    end
  end

  AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (dir_q == '0 && out_q == '0 && ien_q == '0)); // R8
  AST_MASK_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_live && sel == SEL_OUT) |=>
      ((out_q & ~$past(wmask)) == ($past(out_q) & ~$past(wmask)))); // R3
  AST_WRITE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clken_q && !srst_q && sel == SEL_DIR) |=> $stable(dir_q)); // R6

endmodule

// File: rtl/mwgpio.sv
module mwgpio #(
  parameter int NPINS   = 16,
  parameter int NSHARED = 8,
  parameter int ADDR_W  = 8,
  parameter int SYNC_N  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [2*NPINS-1:0] bus_wdata,
  output logic [2*NPINS-1:0] bus_rdata,
  input  logic [NPINS-1:0]   pin_in,
  output logic [NPINS-1:0]   pin_out,
  output logic [NPINS-1:0]   pin_oe,
  output logic               irq_shared
);

  logic [1:0]         rst_pipe;
  logic               rst_int_n;
  logic [NPINS-1:0]   pin_state;
  logic [NPINS-1:0]   dir_q;
  logic [NPINS-1:0]   out_q;
  logic [NSHARED-1:0] ien_q;
  logic               clken_q;
  logic               srst_q;

  // Reset asserts at once and is released two edges later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  mwgpio_regs #(
    .NPINS(NPINS), .NSHARED(NSHARED), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_state(pin_state),
    .dir_q(dir_q), .out_q(out_q), .ien_q(ien_q),
    .clken_q(clken_q), .srst_q(srst_q)
  );

  mwgpio_sync #(
    .NPINS(NPINS), .STAGES(SYNC_N)
  ) u_sync (
    .clk(clk), .rst_n(rst_int_n),
    .clk_en(clken_q), .srst(srst_q),
    .pin_in(pin_in), .state(pin_state)
  );

  mwgpio_irq #(
    .NPINS(NPINS), .NSHARED(NSHARED)
  ) u_irq (
    .clk(clk), .rst_n(rst_int_n),
    .clk_en(clken_q), .state(pin_state), .ien(ien_q),
    .irq_o(irq_shared)
  );

  assign pin_out = out_q;
  assign pin_oe  = dir_q;

endmodule

// File: tb/mwgpio_bench.sv
module mwgpio_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out;
  logic [15:0] pin_oe;
  logic        irq_shared;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  mwgpio u_mwgpio (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq_shared(irq_shared)
  );

  // {write offset, write data, read offset, expected read data}
  localparam int NV = 10;
  localparam logic [79:0] VEC [NV] = '{
    {8'h00, 32'h0000_A5C3, 8'h00, 32'h0000_A5C3},  // R1
    {8'h08, 32'hFFFF_1234, 8'h08, 32'h0000_1234},  // R2
    {8'h08, 32'h00F0_FFFF, 8'h08, 32'h0000_12F4},  // R3
    {8'h08, 32'hF000_0000, 8'h08, 32'h0000_02F4},  // R3
    {8'h08, 32'h0000_FFFF, 8'h08, 32'h0000_02F4},  // R3
    {8'h10, 32'hFFFF_FFFF, 8'h10, 32'h0000_00FF},  // R5
    {8'h10, 32'h0000_0081, 8'h10, 32'h0000_0081},  // R5
    {8'h40, 32'hFFFF_FFFF, 8'h40, 32'h0000_0000},  // R9
    {8'h0C, 32'hFFFF_FFFF, 8'h0C, 32'h0000_0000},  // R4
    {8'h00, 32'h0000_0000, 8'h00, 32'h0000_0000}   // R1
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finished");
    summary();
  end

  initial begin
    logic [31:0] rd;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10: reset state
    bus_read(8'h14, rd); check("R10 enable reg", rd, 32'h0);
    bus_read(8'h00, rd); check("R10 direction", rd, 32'h0);
    check("R10 pin_oe", {16'h0, pin_oe}, 32'h0);
    check("R10 pin_out", {16'h0, pin_out}, 32'h0);
    check("R10 irq", {31'h0, irq_shared}, 32'h0);

    // R6: writes ignored before the block is enabled
    bus_write(8'h08, 32'hFFFF_FFFF);
    check("R6 out before enable", {16'h0, pin_out}, 32'h0);

    // R8: bring-up sequence, writes ignored while in soft reset
    bus_write(8'h14, 32'h3);
    bus_read(8'h14, rd); check("R8 enable reads 3", rd, 32'h3);
    bus_write(8'h00, 32'h0000_FFFF);
    bus_read(8'h00, rd); check("R8 dir write in reset", rd, 32'h0);
    bus_write(8'h14, 32'h1);
    bus_read(8'h14, rd); check("R8 enable reads 1", rd, 32'h1);

    for (int i = 0; i < NV; i++) begin
      bus_write(VEC[i][79:72], VEC[i][71:40]);
      bus_read(VEC[i][39:32], rd);
      check($sformatf("vector %0d (R1 R2 R3 R4 R5 R9)", i), rd, VEC[i][31:0]);
    end
    check("R2 pin_out", {16'h0, pin_out}, 32'h0000_02F4);

    // R1: direction drives pin_oe
    bus_write(8'h00, 32'h0000_00F0);
    check("R1 pin_oe", {16'h0, pin_oe}, 32'h0000_00F0);

    // R9: deselected read returns zero
    @(negedge clk);
    bus_addr = 8'h00; bus_sel = 1'b0;
    #1 check("R9 deselected read", bus_rdata, 32'h0);

    // R4: two-edge synchronizer latency
    @(negedge clk);
    pin_in = 16'h5A3C;
    bus_read(8'h0C, rd); check("R4 after one edge", rd, 32'h0);
    bus_read(8'h0C, rd); check("R4 after two edges", rd, 32'h0000_5A3C);
    check("R5 irq no enabled pin high", {31'h0, irq_shared}, 32'h0);

    // R5: lower pins do not raise the interrupt
    pin_in = 16'h00FF;
    repeat (3) @(negedge clk);
    check("R5 lower pins ignored", {31'h0, irq_shared}, 32'h0);
    pin_in = 16'h0100;
    repeat (3) @(negedge clk);
    check("R5 pin8 enabled high", {31'h0, irq_shared}, 32'h1);
    bus_write(8'h10, 32'h0000_0002);
    check("R5 pin8 disabled", {31'h0, irq_shared}, 32'h0);
    pin_in = 16'h0300;
    repeat (3) @(negedge clk);
    check("R5 pin9 enabled high", {31'h0, irq_shared}, 32'h1);

    // R7: clock off freezes sampling and silences the interrupt
    bus_write(8'h14, 32'h0);
    check("R7 irq low with clock off", {31'h0, irq_shared}, 32'h0);
    pin_in = 16'hFFFF;
    repeat (3) @(negedge clk);
    bus_read(8'h0C, rd); check("R7 pin state frozen", rd, 32'h0000_0300);
    bus_write(8'h00, 32'h0000_0001);
    bus_read(8'h00, rd); check("R6 dir write with clock off", rd, 32'h0000_00F0);
    bus_write(8'h14, 32'h1);
    repeat (2) @(negedge clk);
    bus_read(8'h0C, rd); check("R7 sampling resumes", rd, 32'h0000_FFFF);
    check("R7 irq returns", {31'h0, irq_shared}, 32'h1);

    // R8: shutdown clears state
    bus_write(8'h14, 32'h2);
    repeat (2) @(negedge clk);
    bus_read(8'h14, rd); check("R8 enable reads 2", rd, 32'h2);
    bus_read(8'h00, rd); check("R8 dir cleared", rd, 32'h0);
    bus_read(8'h08, rd); check("R8 out cleared", rd, 32'h0);
    bus_read(8'h10, rd); check("R8 ien cleared", rd, 32'h0);
    bus_read(8'h0C, rd); check("R8 pin state cleared", rd, 32'h0);
    check("R8 pin_out", {16'h0, pin_out}, 32'h0);
    check("R8 irq", {31'h0, irq_shared}, 32'h0);

    summary();
  end

endmodule